// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state the system takes when the core raises its sleep request (the wait-for-interrupt or wait-for-event hint). The choice rests on three inputs. One is the core's deep-sleep input. The other two are control bits: a power-down bit and a regulator low-power bit. The block drives the enables for the core clock, peripheral clocks, oscillators and core power, plus the regulator low-power control. It also handles the return to run mode. A return from Stop or Standby passes through a startup wait. The wait is longer when the regulator was in low-power mode or the core domain was powered off.

A small two-register bus gives software access to the block. The control register holds the mode bits, the backup-domain write gate, the supply detector enable and a 3-bit detector threshold. The same register also holds the write-one flag-clear bits. The status register reports the wakeup flag, the standby flag and the detector output, and it holds three wakeup-pin enables. Leaving Standby acts like a reset of the core-domain control state. The pin enables and the status flags survive it.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state code `mode_st` is 0 (run), and the enables `{core_clk_en, periph_clk_en, osc_en, core_pwr_en}` read 4'b1111. Both registers read 0, and `bkp_wr_en` and `reg_lp` are 0.
- R2: A `sleep_req` pulse in run with `deep_sleep`=0 gives state 1 (sleep) one cycle later, with enables 4'b0111. `wake_irq` then returns the block to run one cycle later.
- R3: A `sleep_req` pulse with `deep_sleep`=1 and control bit 1 clear gives state 2 (stop), with enables 4'b0001 and `reg_lp` equal to control bit 0. In stop, `wake_irq` is ignored. `wake_evt` moves the block to state 4 (wake, enables 4'b0011) for NORM_DLY cycles, or LP_DLY cycles when control bit 0 is set. Run follows, and `rc_clk_force` is high for its first cycle only.
- R4: A `sleep_req` pulse with `deep_sleep`=1 and control bit 1 set gives state 3 (standby), with enables 4'b0000. `wake_evt` and `wake_irq` are ignored there. Only `rtc_evt` or a rising edge on an enabled wakeup pin leaves standby.
- R5: Leaving standby clears the whole control register and sets the standby flag (status bit 1). The block then spends LP_DLY cycles in wake and returns to run with `rc_clk_force` low. The pin enables are preserved.
- R6: The wakeup flag (status bit 0) is set by `rtc_evt` or by a 0-to-1 edge on `wk_pin[i]` whose enable (status bit 8+i) is set. A disabled pin, or a pin that stays high, does not set it.
- R7: Writing 1 to control bit 2 clears the wakeup flag, and writing 1 to control bit 3 clears the standby flag. Both bits read back 0. If a set and a clear of the same flag fall in one cycle, the set wins.
- R8: `bkp_wr_en` follows control bit 8, which is 0 after reset.
- R9: `det_flag` (also status bit 2) is 1 only when all three hold: the detector enable (control bit 4) is set, the state is not standby, and `supply_lvl` < threshold + THR_BASE. The threshold is control bits 7:5.
- R10: Writes to status bits 2:0 have no effect. Only status bits 10:8 are writable.
- R11: `sleep_req` is ignored outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on, external pin) |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| sleep_req | input | 1 | Core sleep request pulse |
| deep_sleep | input | 1 | Core deep-sleep selection |
| wake_irq | input | 1 | Acknowledged interrupt (sleep exit) |
| wake_evt | input | 1 | Enabled event line (stop exit) |
| wk_pin | input | 3 | Wakeup pins, rising-edge active |
| rtc_evt | input | 1 | Alarm, timer, tamper or time-stamp wakeup |
| supply_lvl | input | 4 | Digitised supply level |
| mode_st | output | 3 | State code: 0 run, 1 sleep, 2 stop, 3 standby, 4 wake |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_pwr_en | output | 1 | Core-domain power enable |
| reg_lp | output | 1 | Regulator low-power control |
| rc_clk_force | output | 1 | Select internal RC clock after stop exit |
| bkp_wr_en | output | 1 | Backup-domain write permission |
| det_flag | output | 1 | Supply below threshold |

## Verification
The flag logic can see a set and a clear of the same flag in one cycle. The bench provokes this by writing the wakeup-flag clear bit in the cycle that `rtc_evt` pulses, and it requires the flag to stay set. A standby exit can also coincide with the wakeup flag being set: the same `rtc_evt` pulse both ends standby and sets the flag. The bench requires both flags set and the control register cleared afterwards. The bench also sweeps every combination of deep-sleep, power-down and regulator bit, and every threshold against every supply level.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NORM_DLY = 2,
  parameter int LP_DLY   = 6,
  parameter int LVL_W    = 4,
  parameter int THR_BASE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             sleep_req,
  input  logic             deep_sleep,
  input  logic             wake_irq,
  input  logic             wake_evt,
  input  logic [2:0]       wk_pin,
  input  logic             rtc_evt,
  input  logic [LVL_W-1:0] supply_lvl,
  output logic [2:0]       mode_st,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             core_pwr_en,
  output logic             reg_lp,
  output logic             rc_clk_force,
  output logic             bkp_wr_en,
  output logic             det_flag
);
  localparam int CW = $clog2(LP_DLY + 1);
  localparam logic [2:0] ST_RUN = 3'd0, ST_SLEEP = 3'd1, ST_STOP = 3'd2,
                         ST_STBY = 3'd3, ST_WAKE = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic          from_stop, rc_q;
  logic          lpr, pdds, det_en, bkp_acc;
  logic [2:0]    thr;
  logic          wuf, sbf;
  logic [2:0]    pin_en, pin_q;

  wire       wr_ctl    = bus_wr && !bus_sel;
  wire       wr_sts    = bus_wr && bus_sel;
  wire [2:0] pin_rise  = wk_pin & ~pin_q & pin_en;
  wire       wake_src  = (|pin_rise) || rtc_evt;
  wire       stby_exit = (st == ST_STBY) && wake_src;

  wire [LVL_W:0] thr_lvl = (LVL_W+1)'(thr) + (LVL_W+1)'(THR_BASE);
  assign det_flag = det_en && (st != ST_STBY) && ({1'b0, supply_lvl} < thr_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpr <= 1'b0; pdds <= 1'b0; det_en <= 1'b0; thr <= 3'd0; bkp_acc <= 1'b0;
    end else if (stby_exit) begin
      lpr <= 1'b0; pdds <= 1'b0; det_en <= 1'b0; thr <= 3'd0; bkp_acc <= 1'b0;
    end else if (wr_ctl) begin
      lpr     <= bus_wdata[0];
      pdds    <= bus_wdata[1];
      det_en  <= bus_wdata[4];
      thr     <= bus_wdata[7:5];
      bkp_acc <= bus_wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wuf <= 1'b0; sbf <= 1'b0; pin_en <= 3'd0; pin_q <= 3'd0;
    end else begin
      pin_q <= wk_pin;
      if (wake_src)                   wuf <= 1'b1;
      else if (wr_ctl && bus_wdata[2]) wuf <= 1'b0;
      if (stby_exit)                  sbf <= 1'b1;
      else if (wr_ctl && bus_wdata[3]) sbf <= 1'b0;
      if (wr_sts) pin_en <= bus_wdata[10:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RUN; cnt <= '0; from_stop <= 1'b0; rc_q <= 1'b0;
    end else begin
      rc_q <= (st == ST_WAKE) && (cnt == '0) && from_stop;
      case (st)
        ST_RUN:
          if (sleep_req) st <= !deep_sleep ? ST_SLEEP : (pdds ? ST_STBY : ST_STOP);
        ST_SLEEP:
          if (wake_irq) st <= ST_RUN;
        ST_STOP:
          if (wake_evt) begin
            st        <= ST_WAKE;
            from_stop <= 1'b1;
            cnt       <= lpr ? CW'(LP_DLY - 1) : CW'(NORM_DLY - 1);
          end
        ST_STBY:
          if (wake_src) begin
            st        <= ST_WAKE;
            from_stop <= 1'b0;
            cnt       <= CW'(LP_DLY - 1);
          end
        ST_WAKE:
          if (cnt == '0) st <= ST_RUN;
          else cnt <= cnt - 1'b1;
        default: st <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_RUN:   {core_clk_en, periph_clk_en, osc_en, core_pwr_en} = 4'b1111;
      ST_SLEEP: {core_clk_en, periph_clk_en, osc_en, core_pwr_en} = 4'b0111;
      ST_STOP:  {core_clk_en, periph_clk_en, osc_en, core_pwr_en} = 4'b0001;
      ST_WAKE:  {core_clk_en, periph_clk_en, osc_en, core_pwr_en} = 4'b0011;
      default:  {core_clk_en, periph_clk_en, osc_en, core_pwr_en} = 4'b0000;
    endcase
  end

  assign mode_st      = st;
  assign reg_lp       = (st == ST_STOP) && lpr;
  assign rc_clk_force = rc_q;
  assign bkp_wr_en    = bkp_acc;
  assign bus_rdata    = bus_sel ? {5'd0, pin_en, 5'd0, det_flag, sbf, wuf}
                                : {7'd0, bkp_acc, thr, det_en, 2'b00, pdds, lpr};

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && sleep_req && !deep_sleep) |=> (mode_st == ST_SLEEP)) else $error("sleep entry"); // R2
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && sleep_req && deep_sleep && !pdds) |=> (mode_st == ST_STOP)) else $error("stop entry"); // R3
  AST_RC_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rc_clk_force |-> ($past(st) == ST_WAKE && st == ST_RUN)) else $error("rc force"); // R3
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STBY && !wake_src) |=> (mode_st == ST_STBY)) else $error("standby hold"); // R4
  AST_STBY_EXIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    stby_exit |=> (sbf && !bkp_wr_en && !pdds && mode_st == ST_WAKE)) else $error("standby exit"); // R5
  AST_WUF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_evt |=> wuf) else $error("wakeup flag"); // R7
  AST_BKP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl && !stby_exit) |=> $stable(bkp_wr_en)) else $error("backup gate"); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && !wake_irq) |=> (mode_st == ST_SLEEP)) else $error("sleep hold"); // R11
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
  localparam int CLK_PER = 10;
  localparam int NORM = 2, LPD = 6, BASE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sleep_req = 0, deep_sleep = 0, wake_irq = 0, wake_evt = 0, rtc_evt = 0;
  logic [2:0] wk_pin = '0, mode_st;
  logic [3:0] supply_lvl = '0;
  logic core_clk_en, periph_clk_en, osc_en, core_pwr_en, reg_lp, rc_clk_force, bkp_wr_en, det_flag;
  int checks = 0, fails = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwr_mode_seq #(.NORM_DLY(NORM), .LP_DLY(LPD), .LVL_W(4), .THR_BASE(BASE)) dut_i (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_wdata, .bus_rdata, .sleep_req, .deep_sleep,
    .wake_irq, .wake_evt, .wk_pin, .rtc_evt, .supply_lvl, .mode_st, .core_clk_en,
    .periph_clk_en, .osc_en, .core_pwr_en, .reg_lp, .rc_clk_force, .bkp_wr_en, .det_flag);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic s, input logic [15:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1; tick(); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output int v);
    bus_sel = s; #1; v = int'(bus_rdata);
  endtask

  function automatic int ens();
    return int'({core_clk_en, periph_clk_en, osc_en, core_pwr_en});
  endfunction

  task automatic request(input logic dp);
    deep_sleep = dp; sleep_req = 1'b1; tick(); sleep_req = 1'b0; deep_sleep = 1'b0;
  endtask

  task automatic count_wake(input string rq, input int exp_n, input int exp_rc);
    int n = 0;
    while (mode_st == 3'd4 && n < 30) begin n++; tick(); end
    chk(rq, n, exp_n);
    chk(rq, int'(mode_st), 0);
    chk(rq, int'(rc_clk_force), exp_rc);
    tick();
    chk(rq, int'(rc_clk_force), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 state", int'(mode_st), 0);
    chk("R1 enables", ens(), 15);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    chk("R1 bkp", int'(bkp_wr_en), 0);
    chk("R1 reg_lp", int'(reg_lp), 0);

    // mode sweep: deep x power-down x regulator bit
    for (int i = 0; i < 8; i++) begin
      logic dp, pd, lp;
      int es;
      {dp, pd, lp} = 3'(i);
      wr(0, {14'd0, pd, lp});
      request(dp);
      es = !dp ? 1 : (pd ? 3 : 2);
      chk("R2/R3/R4 entry state", int'(mode_st), es);
      chk("R2/R3/R4 enables", ens(), es == 1 ? 7 : (es == 2 ? 1 : 0));
      chk("R3 reg_lp", int'(reg_lp), int'(es == 2 && lp));
      if (es == 1) begin
        request(1'b1);
        chk("R11 request in sleep", int'(mode_st), 1);
        wake_irq = 1; tick(); wake_irq = 0;
        chk("R2 sleep exit", int'(mode_st), 0);
      end else if (es == 2) begin
        wake_irq = 1; tick(); wake_irq = 0;
        chk("R3 irq ignored in stop", int'(mode_st), 2);
        wake_evt = 1; tick(); wake_evt = 0;
        chk("R3 wake enables", ens(), 3);
        count_wake("R3 stop wake", lp ? LPD : NORM, 1);
      end else begin
        wr(0, 16'h000C);
        wr(0, 16'h0002);
        wake_evt = 1; wake_irq = 1; tick(); wake_evt = 0; wake_irq = 0;
        chk("R4 evt ignored in standby", int'(mode_st), 3);
        rtc_evt = 1; tick(); rtc_evt = 0;
        chk("R4 standby exit", int'(mode_st), 4);
        count_wake("R5 standby wake", LPD, 0);
        rd(0, v); chk("R5 ctrl cleared", v, 0);
        rd(1, v); chk("R5 flags set", v & 3, 3);
        wr(0, 16'h000C);
        rd(1, v); chk("R7 flags cleared", v & 3, 0);
      end
    end

    // R6 pin edges with only pin 1 enabled
    wr(1, 16'h0200);
    for (int p = 0; p < 3; p++) begin
      wr(0, 16'h0004);
      wk_pin[p] = 1'b1; tick();
      rd(1, v); chk("R6 pin edge", v & 1, int'(p == 1));
      wk_pin[p] = 1'b0; tick();
    end
    wk_pin[1] = 1'b1; tick();
    wr(0, 16'h0004); tick(); tick();
    rd(1, v); chk("R6 steady high", v & 1, 0);
    wk_pin[1] = 1'b0; tick();

    // R7 set and clear collide
    bus_sel = 0; bus_wdata = 16'h0004; bus_wr = 1; rtc_evt = 1; tick(); bus_wr = 0; rtc_evt = 0;
    rd(1, v); chk("R7 set wins", v & 1, 1);
    rd(0, v); wr(0, 16'h01FF); rd(0, v); chk("R10 ctrl readback", v, 16'h01F3);
    chk("R8 bkp on", int'(bkp_wr_en), 1);
    wr(0, 16'h0000); chk("R8 bkp off", int'(bkp_wr_en), 0);
    wr(0, 16'h0004);
    wr(1, 16'h0407);
    rd(1, v); chk("R10 status ro bits", v, 16'h0400);

    // R5 pin-driven standby exit keeps pin enables
    wr(0, 16'h0102); request(1'b1);
    chk("R4 standby", int'(mode_st), 3);
    wk_pin[0] = 1; tick(); wk_pin[0] = 0; tick();
    chk("R4 disabled pin ignored", int'(mode_st), 3);
    wk_pin[2] = 1; tick(); wk_pin[2] = 0;
    chk("R4 enabled pin exit", int'(mode_st), 4);
    chk("R5 bkp cleared", int'(bkp_wr_en), 0);
    count_wake("R5 pin wake", LPD, 0);
    rd(1, v); chk("R5 pin enables kept", v & 16'h0700, 16'h0400);
    wr(0, 16'h000C);

    // R9 detector sweep
    for (int t = 0; t < 8; t++) begin
      wr(0, 16'((t << 5) | 16'h10));
      for (int l = 0; l < 16; l++) begin
        supply_lvl = 4'(l); #1;
        chk("R9 det_flag", int'(det_flag), int'(l < t + BASE));
      end
      rd(1, v); chk("R9 status det", (v >> 2) & 1, int'(15 < t + BASE));
    end
    supply_lvl = 4'd0;
    wr(0, 16'h00E0); #1; chk("R9 det disabled", int'(det_flag), 0);
    wr(0, 16'h00F2); #1; chk("R9 det enabled", int'(det_flag), 1);
    request(1'b1);
    chk("R9 det in standby", int'(det_flag), 0);
    rtc_evt = 1; tick(); rtc_evt = 0;
    count_wake("R5 rtc wake", LPD, 0);
    finish_run();
  end
endmodule